// File: doc/BRIEF.md
# Signed-Digit Scalar Sequencer for Unified Point Operations

This block is the controller of a scalar multiplier on a binary Edwards curve. On a start request it latches a recoded key made of two-bit signed digits. It then runs three set-up steps that load the base point into the working registers. After that it handles the digits one at a time, beginning with the most significant pair. Every digit gets a doubling pass. A digit of plus or minus one also gets an addition pass after its doubling pass.

Doubling and addition use one unified formula, so both passes are the same 25-step micro-sequence. The step index and the phase code drive the register and multiplexer selects of a separate field-arithmetic datapath. The result therefore depends only on the key, never on which operation runs. A digit of minus one needs no field negation. The sequencer pulses a swap strobe that makes the datapath exchange the x and y coordinates of the base point before the addition. A second pulse at the end of the addition swaps them back.

Top module: `edw_scalar_seq`

## Requirements
- R1: After reset the block is idle: busy, done and swap are 0, phase is 2'b00 and step is 0.
- R2: A start sampled while idle latches the key. The next three cycles show phase 2'b01 (set-up) with step 0, 1 and 2 in that order.
- R3: Every operation pass lasts exactly 25 cycles with step counting 0 to 24. The trace is the same for doubling (phase 2'b10) and addition (phase 2'b11).
- R4: Digits are handled from the most significant pair down. During a pass, the digit output shows the pair under work, taken from key bits [2k+1:2k] with k counting down from NDIG-1 to 0.
- R5: A pair of 2'b00 or 2'b10 gets a doubling pass only.
- R6: A pair of 2'b01 gets a doubling pass followed at once by an addition pass, with no swap strobe.
- R7: A pair of 2'b11 gets a doubling pass and then an addition pass. The swap strobe is high for one cycle on step 24 of each of those two passes, and at no other time.
- R8: After the last digit, done is high for exactly one cycle and the block then returns to idle. With w the number of pairs whose low bit is 1, done appears 3 + 25*(NDIG + w) + 1 cycles after the start is sampled.
- R9: A start that arrives while busy is high, including the done cycle, has no effect on the running sequence.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Begin a scalar run (sampled only while idle) |
| key | input | 2*NDIG | Recoded key, NDIG two-bit signed digits |
| busy | output | 1 | High from the first set-up step through the done cycle |
| done | output | 1 | One-cycle end-of-run pulse |
| phase | output | 2 | 00 idle, 01 set-up, 10 doubling, 11 addition |
| step | output | STEP_W | Micro-step index within the current phase |
| digit | output | 2 | Digit pair currently being handled |
| swap | output | 1 | Coordinate-exchange strobe for the base point |

## Verification
Two pairs of functions share a cycle. First, on step 24 of a pass for a minus-one digit, the swap strobe coincides with the pass boundary: either the hand-over from doubling to addition or the advance to the next digit. Second, on the last digit, that same boundary leads straight into done. Keys full of 2'b11 pairs, and keys that end in 2'b11, provoke both cases. A cycle-level reference queue judges every output on every clock, including the cycle where swap and the phase change meet. A start held high across whole runs checks that requests made during the passes and during the done cycle are ignored.

// File: rtl/edw_seq_pkg.sv
package edw_seq_pkg;
  typedef enum logic [2:0] {
    S_IDLE, S_INIT, S_DBL, S_ADD, S_DONE
  } seq_state_t;

  localparam logic [1:0] PH_IDLE = 2'b00;
  localparam logic [1:0] PH_INIT = 2'b01;
  localparam logic [1:0] PH_DBL  = 2'b10;
  localparam logic [1:0] PH_ADD  = 2'b11;

  // low bit of the pair set: the digit is +1 or -1, so an addition follows
  function automatic logic needs_add(input logic [1:0] pair);
    return pair[0];
  endfunction

  // pair 11 stands for -1: the coordinates are exchanged around the addition
  function automatic logic is_negative(input logic [1:0] pair);
    return pair == 2'b11;
  endfunction

  function automatic logic [1:0] phase_of(input seq_state_t s);
    case (s)
      S_INIT:  return PH_INIT;
      S_DBL:   return PH_DBL;
      S_ADD:   return PH_ADD;
      default: return PH_IDLE;
    endcase
  endfunction
endpackage

// File: rtl/edw_seq_keyreg.sv
module edw_seq_keyreg #(
  parameter int NDIG  = 8,
  parameter int KEY_W = 2 * NDIG,
  parameter int CNT_W = $clog2(NDIG + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic             advance,
  input  logic [KEY_W-1:0] key_in,
  output logic [1:0]       digit,
  output logic             last
);
  logic [KEY_W-1:0] key_q;
  logic [CNT_W-1:0] left_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      key_q  <= '0;
      left_q <= '0;
    end else if (load) begin
      key_q  <= key_in;
      left_q <= CNT_W'(NDIG - 1);
    end else if (advance) begin
      key_q  <= {key_q[KEY_W-3:0], 2'b00};
      left_q <= left_q - CNT_W'(1);
    end
  end

  assign digit = key_q[KEY_W-1 -: 2];
  assign last  = (left_q == '0);
endmodule

// File: rtl/edw_seq_stepctr.sv
module edw_seq_stepctr #(
  parameter int STEP_W = 5
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clr,
  input  logic              inc,
  output logic [STEP_W-1:0] step
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)   step <= '0;
    else if (clr) step <= '0;
    else if (inc) step <= step + STEP_W'(1);
  end
endmodule

// File: rtl/edw_scalar_seq.sv
module edw_scalar_seq
  import edw_seq_pkg::*;
#(
  parameter int NDIG       = 8,
  parameter int OP_STEPS   = 25,
  parameter int INIT_STEPS = 3,
  parameter int KEY_W      = 2 * NDIG,
  parameter int STEP_W     = $clog2(OP_STEPS)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic [KEY_W-1:0]  key,
  output logic              busy,
  output logic              done,
  output logic [1:0]        phase,
  output logic [STEP_W-1:0] step,
  output logic [1:0]        digit,
  output logic              swap
);
  localparam logic [STEP_W-1:0] OP_LAST   = STEP_W'(OP_STEPS - 1);
  localparam logic [STEP_W-1:0] INIT_LAST = STEP_W'(INIT_STEPS - 1);

  seq_state_t state_q, state_d;
  logic accept, init_end, pass_end, digit_end, last_digit;
  logic step_clr, step_inc;

  edw_seq_keyreg #(.NDIG(NDIG), .KEY_W(KEY_W)) u_keyreg (
    .clk(clk), .rst_n(rst_n), .load(accept),
    .advance(digit_end && !last_digit), .key_in(key),
    .digit(digit), .last(last_digit)
  );

  edw_seq_stepctr #(.STEP_W(STEP_W)) u_stepctr (
    .clk(clk), .rst_n(rst_n), .clr(step_clr), .inc(step_inc), .step(step)
  );

  // named events for the checker and for readability
  assign accept    = (state_q == S_IDLE) && start;
  assign init_end  = (state_q == S_INIT) && (step == INIT_LAST);
  assign pass_end  = ((state_q == S_DBL) || (state_q == S_ADD)) && (step == OP_LAST);
  assign digit_end = pass_end && ((state_q == S_ADD) || !needs_add(digit));

  assign step_clr = accept || init_end || pass_end || (state_q == S_DONE);
  assign step_inc = (state_q == S_INIT) || (state_q == S_DBL) || (state_q == S_ADD);

  always_comb begin
    state_d = state_q;
    case (state_q)
      S_IDLE: if (accept) state_d = S_INIT;
      S_INIT: if (init_end) state_d = S_DBL;
      S_DBL: if (pass_end) begin
        if (needs_add(digit)) state_d = S_ADD;
        else if (last_digit)  state_d = S_DONE;
        else                  state_d = S_DBL;
      end
      S_ADD: if (pass_end) state_d = last_digit ? S_DONE : S_DBL;
      S_DONE:  state_d = S_IDLE;
      default: state_d = S_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state_q <= S_IDLE;
    else        state_q <= state_d;
  end

  assign busy  = (state_q != S_IDLE);
  assign done  = (state_q == S_DONE);
  assign phase = phase_of(state_q);
  assign swap  = pass_end && is_negative(digit);
endmodule

// File: rtl/edw_scalar_seq_chk.sv
module edw_scalar_seq_chk #(
  parameter int OP_STEPS = 25,
  parameter int STEP_W   = 5
) (
  input logic              clk,
  input logic              rst_n,
  input logic              busy,
  input logic              done,
  input logic [1:0]        phase,
  input logic [STEP_W-1:0] step,
  input logic [1:0]        digit,
  input logic              swap,
  input logic              last_digit
);
  localparam logic [STEP_W-1:0] LAST = STEP_W'(OP_STEPS - 1);

  AST_INIT_ENTRY: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> (phase == 2'b01 && step == '0)); // R2
  AST_STEP_ORDER: assert property (@(posedge clk) disable iff (!rst_n)
    (phase[1] && step != LAST) |=> (phase == $past(phase) && step == $past(step) + STEP_W'(1))); // R3
  AST_STEP_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    phase[1] |-> (step <= LAST)); // R3
  AST_ZERO_NO_ADD: assert property (@(posedge clk) disable iff (!rst_n)
    (phase == 2'b10 && step == LAST && !digit[0]) |=> (phase != 2'b11)); // R5
  AST_ADD_FOLLOWS: assert property (@(posedge clk) disable iff (!rst_n)
    (phase == 2'b10 && step == LAST && digit[0]) |=> (phase == 2'b11 && step == '0)); // R6
  AST_SWAP_PLACE: assert property (@(posedge clk) disable iff (!rst_n)
    swap |-> (phase[1] && step == LAST && digit == 2'b11)); // R7
  AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> (!done && !busy)); // R8
  AST_DONE_AFTER_LAST: assert property (@(posedge clk) disable iff (!rst_n)
    (phase[1] && step == LAST && last_digit && (phase == 2'b11 || !digit[0])) |=> done); // R8
  AST_START_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && phase != 2'b01) |=> (phase != 2'b01)); // R9
endmodule

bind edw_scalar_seq edw_scalar_seq_chk #(.OP_STEPS(OP_STEPS), .STEP_W(STEP_W)) i_chk (
  .clk(clk), .rst_n(rst_n), .busy(busy), .done(done), .phase(phase),
  .step(step), .digit(digit), .swap(swap), .last_digit(last_digit)
);

// File: tb/test_edw_scalar_seq.sv
module test_edw_scalar_seq;
  localparam int N = 8;
  localparam int KW = 2 * N;
  localparam int SW = 5;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic start = 1'b0;
  logic [KW-1:0] key = '0;
  logic busy, done, swap;
  logic [1:0] phase, digit;
  logic [SW-1:0] step;

  always #4 clk = ~clk;

  edw_scalar_seq #(.NDIG(N)) i_edw_scalar_seq (
    .clk(clk), .rst_n(rst_n), .start(start), .key(key), .busy(busy),
    .done(done), .phase(phase), .step(step), .digit(digit), .swap(swap)
  );

  typedef struct packed {
    logic busy; logic done; logic [1:0] ph; logic [SW-1:0] st;
    logic sw; logic dv; logic [1:0] dg;
  } exp_t;

  exp_t q[$];
  bit prev_busy = 0;
  int checks = 0, errors = 0;
  int run_cnt = 0, run_exp = 0;
  bit counting = 0;

  task automatic push(input logic [1:0] ph, input int s, input logic sw, input logic dv, input logic [1:0] dg);
    exp_t e;
    e.busy = 1; e.done = 0; e.ph = ph; e.st = SW'(s); e.sw = sw; e.dv = dv; e.dg = dg;
    q.push_back(e);
  endtask

  // expected trace of one run, built from the requirements
  task automatic build(input logic [KW-1:0] k);
    exp_t e;
    int w = 0;
    for (int i = 0; i < 3; i++) push(2'b01, i, 0, 0, 2'b00);                    // R2
    for (int d = N - 1; d >= 0; d--) begin
      logic [1:0] dg = k[2*d +: 2];
      for (int s = 0; s < 25; s++) push(2'b10, s, (dg == 2'b11) && s == 24, 1, dg); // R3 R5
      if (dg[0]) begin
        w++;
        for (int s = 0; s < 25; s++) push(2'b11, s, (dg == 2'b11) && s == 24, 1, dg); // R6 R7
      end
    end
    e = '0; e.busy = 1; e.done = 1;
    q.push_back(e);
    run_exp = 3 + 25 * (N + w) + 1;                                              // R8
  endtask

  task automatic compare(input exp_t e);
    string tag;
    bit bad = 0;
    checks++;
    if (busy !== e.busy || done !== e.done || phase !== e.ph || step !== e.st || swap !== e.sw) bad = 1;
    if (e.dv && digit !== e.dg) bad = 1;
    if (bad) begin
      errors++;
      if (e.sw || swap) tag = "R7";
      else if (e.dv && digit !== e.dg) tag = "R4";
      else if (e.done) tag = "R8";
      else if (e.ph == 2'b01) tag = "R2";
      else if (e.ph == 2'b11) tag = "R6";
      else if (e.ph == 2'b10) tag = (e.dg[0] == 1'b0) ? "R5" : "R3";
      else tag = "R9";
      $display("FAIL %s: got busy=%b done=%b ph=%b st=%0d sw=%b dg=%b, exp busy=%b done=%b ph=%b st=%0d sw=%b dg=%b",
               tag, busy, done, phase, step, swap, digit, e.busy, e.done, e.ph, e.st, e.sw, e.dg);
    end
  endtask

  task automatic tick(input bit st, input logic [KW-1:0] k);
    exp_t e;
    bit acc;
    start = st; key = k;
    acc = st && !prev_busy;
    @(posedge clk);
    #2;
    if (acc) begin
      build(k);
      counting = 1; run_cnt = 0;
    end
    if (counting) run_cnt++;
    e = (q.size() > 0) ? q.pop_front() : exp_t'('0);
    compare(e);
    if (done === 1'b1 && counting) begin
      counting = 0;
      checks++;
      if (run_cnt != run_exp) begin
        errors++;
        $display("FAIL R8: cycles to done got %0d exp %0d", run_cnt, run_exp);
      end
    end
    prev_busy = e.busy;
  endtask

  task automatic run_key(input logic [KW-1:0] k);
    tick(1, k);
    for (int i = 0; i < 2000 && q.size() > 0; i++) tick(0, k);
    tick(0, '0);
  endtask

  initial begin
    #(8 * 150000);
    errors++; checks++;
    $display("FAIL watchdog expired");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    exp_t z;
    #3;
    z = '0;
    compare(z);                       // R1 during reset
    #20 rst_n = 1'b1;
    @(negedge clk);
    compare(z);                       // R1 after reset
    tick(0, '0); tick(0, '0);
    run_key(16'h0000);                // R5 all doubling
    run_key(16'h5555);                // R6 all plus one
    run_key(16'hFFFF);                // R7 all minus one
    run_key(16'hAAAA);                // R5 pair 10
    run_key(16'b11_10_01_00_01_11_00_11); // R4 mixed, ends in minus one
    // R9: start held high across runs, including the done cycle
    tick(1, 16'h00C3);
    for (int i = 0; i < 2000 && q.size() > 0; i++) tick(1, 16'h5A5A);
    for (int i = 0; i < 2000 && (q.size() > 0 || prev_busy); i++) tick(1, 16'h3C3C);
    for (int i = 0; i < 2000 && q.size() > 0; i++) tick(0, '0);
    tick(0, '0);
    for (int r = 0; r < 4; r++) run_key(KW'($urandom(r + 7)));
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule